// File: doc/BRIEF.md
# Dual-Channel IDE I/O Address Decoder

This block sits between a host I/O request port and two IDE channels. For each request it compares the address against five windows: a command-block window and a control-block window for each channel, plus one bus-master window that both channels share. It then sends a strobe to the one channel that owns the access, together with the access kind, the offset inside the window, the direction, the size and the write data. Every base and size comes from a configuration input, so firmware or a parent block can move the windows at run time.

The decoder also follows drive selection on each channel. It watches writes to the drive-select register in the command block and keeps a master/slave selection bit per channel. When the selected drive is not fitted, the decoder handles command-block and control-block accesses itself. Such a read returns a fill byte. Such a write is dropped. Any access wider than a byte raises a size error.

An access that hits no window raises an address error. While I/O decoding is disabled, every request is dropped without effect. All outputs are registered and appear one clock after the request.

Top module: `ide_io_decoder`

## Requirements
- R1: After a synchronous active-low reset, all strobes, error flags, pass-through fields and both drive-selection bits read 0.
- R2: While `io_en` is 0, a request produces no strobe and no error, and it leaves the drive selection unchanged.
- R3: When windows overlap, the first match wins, in this order: primary command, primary control, secondary command, secondary control, bus-master.
- R4: A window covers base <= address < base + size. The reported offset is address minus base. The kind code is 0 for a command-block access, 1 for a control-block access and 2 for a bus-master access. `chan_stb` bit 0 is the primary channel and bit 1 is the secondary channel.
- R5: In the bus-master window, offsets 0 to 7 strobe the primary channel. Offsets 8 and above strobe the secondary channel with 8 subtracted.
- R6: A write to command-block offset 6 of a channel copies write-data bit 4 into that channel's selection bit (0 = master, 1 = slave). Reads, other offsets and other windows leave the bit alone. The new selection is used for that same access.
- R7: A byte access (size code 0) to the command or control block of a channel whose selected drive is absent gives no strobe. A read raises `absent_rd` with `absent_rdata` = 0xFF. A write has no visible effect. Presence bit index = 2*channel + selection.
- R8: An access wider than a byte (size code 1 = 16 bits, 2 = 32 bits) to an absent drive's command or control block raises `size_err` and gives no strobe and no `absent_rd`.
- R9: An enabled request that matches no window raises `addr_err` and strobes nothing.
- R10: Each output reflects the request from exactly one clock earlier. Strobes and flags last one cycle and return to 0 on an idle cycle.
- R11: Bus-master accesses strobe their channel whether or not a drive is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_en | input | 1 | I/O decoding enable |
| dev_present | input | 4 | Drive fitted, index 2*channel + selection |
| pri_cmd_base | input | AW | Primary command-block base |
| pri_cmd_size | input | AW | Primary command-block size |
| pri_ctl_base | input | AW | Primary control-block base |
| pri_ctl_size | input | AW | Primary control-block size |
| sec_cmd_base | input | AW | Secondary command-block base |
| sec_cmd_size | input | AW | Secondary command-block size |
| sec_ctl_base | input | AW | Secondary control-block base |
| sec_ctl_size | input | AW | Secondary control-block size |
| bm_base | input | AW | Shared bus-master base |
| bm_size | input | AW | Shared bus-master size |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | AW | I/O address |
| req_wdata | input | DW | Write data |
| chan_stb | output | 2 | Per-channel strobe |
| acc_kind | output | 2 | 0 command, 1 control, 2 bus-master |
| acc_off | output | AW | Offset inside the channel's window |
| acc_write | output | 1 | Direction of the strobed access |
| acc_size | output | 2 | Size of the strobed access |
| acc_wdata | output | DW | Write data of the strobed access |
| absent_rd | output | 1 | Byte read served for an absent drive |
| absent_rdata | output | 8 | Fill byte for that read |
| size_err | output | 1 | Non-byte access to an absent drive |
| addr_err | output | 1 | Enabled access outside every window |
| sel_drive | output | 2 | Per-channel selection (bit 0 primary) |

## Verification
The drive-selection bits are the only state that lasts beyond one request. A wrong selection bit shows on `sel_drive` one clock after the write that set it. It also decides, on the very next command or control access to that channel, whether the access is strobed or served as absent. All other logic is combinational between input and output flops. A wrong priority, window edge or bus-master split therefore shows at `chan_stb`, `acc_kind` or `acc_off` one clock after the request that exposes it. The bench compares every output against its model on every clock, so the first wrong cycle is reported.

// File: rtl/ide_dec_pkg.sv
// Shared definitions for the IDE I/O decoder.
// Assumes: the window order below is the decode priority order.
package ide_dec_pkg;
    typedef enum logic [1:0] {
        KIND_CMD = 2'd0,
        KIND_CTL = 2'd1,
        KIND_BM  = 2'd2
    } acc_kind_e;

    localparam int NUM_WIN = 5;   // pri cmd, pri ctl, sec cmd, sec ctl, bus-master
    localparam int WIN_BM  = 4;
    localparam int NUM_CH  = 2;
endpackage

// File: rtl/ide_window_match.sv
// Range comparator for one decode window.
// Hit when base <= addr < base + size. The offset is addr - base.
// Assumes: unsigned addresses. Using the subtraction avoids overflow of base + size.
module ide_window_match #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    output logic          hit,
    output logic [AW-1:0] off
);
    // offset and bounds test
    always_comb begin
        off = addr - base;
        hit = (addr >= base) && (off < size);
    end
endmodule

// File: rtl/ide_drive_select.sv
// Per-channel master/slave selection bit, updated by snooped writes.
// Assumes: snoop_wr is already qualified by enable, window and offset.
module ide_drive_select (
    input  logic clk,
    input  logic rst_n,
    input  logic snoop_wr,
    input  logic snoop_bit,
    output logic sel_q,
    output logic sel_next
);
    // selection seen by the current access
    always_comb sel_next = snoop_wr ? snoop_bit : sel_q;

    // hold selection between snooped writes
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_next;
    end

    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_wr |=> $stable(sel_q));
endmodule

// File: rtl/ide_io_decoder.sv
// Dual-channel IDE I/O decoder: five prioritised windows, a bus-master split,
// drive-select snooping and absent-drive handling. Registered outputs, 1-cycle latency.
// Assumes: one request per cycle. The window order in ide_dec_pkg is the priority.
module ide_io_decoder
    import ide_dec_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 32,
    parameter int          BM_SPLIT = 8,
    parameter int          SEL_OFF  = 6,
    parameter int          SEL_BIT  = 4,
    parameter logic [7:0]  FILL     = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_en,
    input  logic [3:0]    dev_present,
    input  logic [AW-1:0] pri_cmd_base,
    input  logic [AW-1:0] pri_cmd_size,
    input  logic [AW-1:0] pri_ctl_base,
    input  logic [AW-1:0] pri_ctl_size,
    input  logic [AW-1:0] sec_cmd_base,
    input  logic [AW-1:0] sec_cmd_size,
    input  logic [AW-1:0] sec_ctl_base,
    input  logic [AW-1:0] sec_ctl_size,
    input  logic [AW-1:0] bm_base,
    input  logic [AW-1:0] bm_size,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [1:0]    chan_stb,
    output logic [1:0]    acc_kind,
    output logic [AW-1:0] acc_off,
    output logic          acc_write,
    output logic [1:0]    acc_size,
    output logic [DW-1:0] acc_wdata,
    output logic          absent_rd,
    output logic [7:0]    absent_rdata,
    output logic          size_err,
    output logic          addr_err,
    output logic [1:0]    sel_drive
);
    localparam int IDXW = $clog2(NUM_WIN);
    localparam logic [AW-1:0] SPLIT_OFF = AW'(BM_SPLIT);
    localparam logic [AW-1:0] SNOOP_OFF = AW'(SEL_OFF);

    logic [AW-1:0] win_base [NUM_WIN];
    logic [AW-1:0] win_size [NUM_WIN];
    logic [AW-1:0] win_off  [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;

    assign win_base[0] = pri_cmd_base;  assign win_size[0] = pri_cmd_size;
    assign win_base[1] = pri_ctl_base;  assign win_size[1] = pri_ctl_size;
    assign win_base[2] = sec_cmd_base;  assign win_size[2] = sec_cmd_size;
    assign win_base[3] = sec_ctl_base;  assign win_size[3] = sec_ctl_size;
    assign win_base[4] = bm_base;       assign win_size[4] = bm_size;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        ide_window_match #(.AW(AW)) u_match (
            .addr (req_addr),
            .base (win_base[w]),
            .size (win_size[w]),
            .hit  (win_hit[w]),
            .off  (win_off[w])
        );
    end

    logic            any_hit;
    logic [IDXW-1:0] hit_idx;
    logic [AW-1:0]   match_off;

    // priority pick: lowest-numbered matching window wins
    always_comb begin
        any_hit   = 1'b0;
        hit_idx   = '0;
        match_off = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (win_hit[w]) begin
                any_hit   = 1'b1;
                hit_idx   = IDXW'(w);
                match_off = win_off[w];
            end
        end
    end

    logic          live, is_bm, tgt_ch;
    logic [AW-1:0] tgt_off;
    acc_kind_e     tgt_kind;
    logic [NUM_CH-1:0] snoop_wr, sel_q, sel_next;

    // route to channel and build local offset and kind
    always_comb begin
        live  = io_en && req_valid;
        is_bm = (hit_idx == IDXW'(WIN_BM));
        if (is_bm) begin
            tgt_ch   = (match_off >= SPLIT_OFF);
            tgt_off  = tgt_ch ? (match_off - SPLIT_OFF) : match_off;
            tgt_kind = KIND_BM;
        end else begin
            tgt_ch   = hit_idx[1];
            tgt_off  = match_off;
            tgt_kind = hit_idx[0] ? KIND_CTL : KIND_CMD;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // write to this channel's drive-select register
        assign snoop_wr[c] = live && any_hit && !is_bm && !hit_idx[0] &&
                             (hit_idx[1] == 1'(c)) && req_write && (match_off == SNOOP_OFF);
        ide_drive_select u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .snoop_wr  (snoop_wr[c]),
            .snoop_bit (req_wdata[SEL_BIT]),
            .sel_q     (sel_q[c]),
            .sel_next  (sel_next[c])
        );
    end

    logic dev_ok, do_stb, do_abs;

    // presence gating for command/control accesses
    always_comb begin
        dev_ok = is_bm || dev_present[{tgt_ch, sel_next[tgt_ch]}];
        do_stb = live && any_hit && dev_ok;
        do_abs = live && any_hit && !dev_ok;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_stb     <= '0;
            acc_kind     <= '0;
            acc_off      <= '0;
            acc_write    <= 1'b0;
            acc_size     <= '0;
            acc_wdata    <= '0;
            absent_rd    <= 1'b0;
            absent_rdata <= '0;
            size_err     <= 1'b0;
            addr_err     <= 1'b0;
        end else begin
            chan_stb     <= do_stb ? (tgt_ch ? 2'b10 : 2'b01) : 2'b00;
            acc_kind     <= do_stb ? tgt_kind : KIND_CMD;
            acc_off      <= do_stb ? tgt_off : '0;
            acc_write    <= do_stb && req_write;
            acc_size     <= do_stb ? req_size : 2'b00;
            acc_wdata    <= do_stb ? req_wdata : '0;
            absent_rd    <= do_abs && (req_size == 2'b00) && !req_write;
            absent_rdata <= (do_abs && (req_size == 2'b00) && !req_write) ? FILL : 8'h00;
            size_err     <= do_abs && (req_size != 2'b00);
            addr_err     <= live && !any_hit;
        end
    end

    assign sel_drive = sel_q;

    assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_stb));
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |=> (chan_stb == 2'b00 && !addr_err && !size_err && !absent_rd));
    assert_err_no_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (chan_stb == 2'b00));
    assert_bm_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_stb != 2'b00 && acc_kind == KIND_BM) |-> (acc_off < SPLIT_OFF));
    assert_size_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> (chan_stb == 2'b00 && !absent_rd));
endmodule

// File: tb/ide_io_decoder_test.sv
// Bench: behavioural reference model, compared on every clock at the falling edge.
module ide_io_decoder_test;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_en = 1'b0;
    logic [3:0] dev_present = 4'hF;
    logic [AW-1:0] base_v [5];
    logic [AW-1:0] size_v [5];
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_size = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;

    logic [1:0] chan_stb, acc_kind, acc_size, sel_drive;
    logic [AW-1:0] acc_off;
    logic acc_write, absent_rd, size_err, addr_err;
    logic [DW-1:0] acc_wdata;
    logic [7:0] absent_rdata;

    always #10 clk = ~clk;   // 50 MHz

    ide_io_decoder uut (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .dev_present(dev_present),
        .pri_cmd_base(base_v[0]), .pri_cmd_size(size_v[0]),
        .pri_ctl_base(base_v[1]), .pri_ctl_size(size_v[1]),
        .sec_cmd_base(base_v[2]), .sec_cmd_size(size_v[2]),
        .sec_ctl_base(base_v[3]), .sec_ctl_size(size_v[3]),
        .bm_base(base_v[4]), .bm_size(size_v[4]),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .chan_stb(chan_stb), .acc_kind(acc_kind), .acc_off(acc_off),
        .acc_write(acc_write), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .absent_rd(absent_rd), .absent_rdata(absent_rdata),
        .size_err(size_err), .addr_err(addr_err), .sel_drive(sel_drive)
    );

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit finished = 0;
    int want_base [5] = '{16'h1F0, 16'h3F4, 16'h170, 16'h374, 16'hC000};
    int want_size [5] = '{8, 4, 8, 4, 16};
    bit want_io = 1'b1;
    logic [3:0] want_pres = 4'hF;
    int msel [2] = '{0, 0};
    logic [67:0] exp_vec = '0;
    string exp_tag = "R1";

    function automatic logic [67:0] actual_vec();
        return {chan_stb, acc_kind, acc_off, acc_write, acc_size, acc_wdata,
                absent_rd, absent_rdata, size_err, addr_err, sel_drive};
    endfunction

    task automatic compare();
        n_checks++;
        if (actual_vec() !== exp_vec) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", exp_tag, actual_vec(), exp_vec);
        end
    endtask

    // reference model for the request now on the inputs
    task automatic model(string tag, bit v, bit wr, int a, int sz, int wd);
        int hit = -1, off = 0, ch = 0, kind = 0, o = 0;
        bit pres = 1;
        logic [1:0] e_stb = 0, e_kind = 0, e_size = 0;
        logic [AW-1:0] e_off = 0;
        logic e_wr = 0, e_ard = 0, e_serr = 0, e_aerr = 0;
        logic [7:0] e_ad = 0;
        logic [DW-1:0] e_wd = 0;
        if (v && want_io) begin
            for (int w = 4; w >= 0; w--)
                if (a >= want_base[w] && a - want_base[w] < want_size[w]) begin
                    hit = w; off = a - want_base[w];
                end
            if (hit < 0) e_aerr = 1;
            else begin
                if (hit < 4) begin
                    ch = hit / 2; kind = hit % 2; o = off;
                    if (kind == 0 && wr && off == 6) msel[ch] = (wd >> 4) & 1;
                    pres = want_pres[ch * 2 + msel[ch]];
                end else begin
                    ch = (off >= 8); o = ch ? off - 8 : off; kind = 2; pres = 1;
                end
                if (pres) begin
                    e_stb = ch ? 2'b10 : 2'b01; e_kind = 2'(kind); e_off = AW'(o);
                    e_wr = wr; e_size = 2'(sz); e_wd = DW'(wd);
                end else if (sz != 0) e_serr = 1;
                else if (!wr) begin e_ard = 1; e_ad = 8'hFF; end
            end
        end
        exp_vec = {e_stb, e_kind, e_off, e_wr, e_size, e_wd, e_ard, e_ad, e_serr, e_aerr,
                   1'(msel[1]), 1'(msel[0])};
        exp_tag = tag;
    endtask

    // one clock: check last request, apply settings, drive next request
    task automatic step(string tag, bit v, bit wr, int a, int sz, int wd);
        @(negedge clk);
        compare();
        io_en = want_io;
        dev_present = want_pres;
        for (int w = 0; w < 5; w++) begin
            base_v[w] = AW'(want_base[w]);
            size_v[w] = AW'(want_size[w]);
        end
        req_valid = v; req_write = wr; req_addr = AW'(a);
        req_size = 2'(sz); req_wdata = DW'(wd);
        model(tag, v, wr, a, sz, wd);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            n_checks++; n_fail++;
            $display("FAIL R10: watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 5; w++) begin
            base_v[w] = AW'(want_base[w]); size_v[w] = AW'(want_size[w]);
        end
        repeat (3) @(negedge clk);
        compare();                               // R1 during reset
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, 0);               // R1 first cycle after reset
        // R4 window edges and offsets
        step("R4", 1, 0, 16'h1F0, 0, 0);
        step("R4", 1, 0, 16'h1F7, 0, 0);
        step("R9", 1, 0, 16'h1F8, 0, 0);
        step("R9", 1, 1, 16'h1EF, 0, 0);
        step("R4", 1, 0, 16'h3F4, 0, 0);
        step("R4", 1, 0, 16'h377, 0, 0);
        step("R4", 1, 1, 16'h172, 2, 32'hCAFE_1234);
        step("R10", 0, 0, 0, 0, 0);
        // R5 bus-master split
        step("R5", 1, 0, 16'hC000, 0, 0);
        step("R5", 1, 0, 16'hC007, 0, 0);
        step("R5", 1, 1, 16'hC008, 2, 32'h55);
        step("R5", 1, 0, 16'hC00F, 1, 0);
        step("R9", 1, 0, 16'hC010, 0, 0);
        // R6 drive select snooping
        step("R6", 1, 1, 16'h1F6, 0, 8'h10);
        step("R6", 1, 0, 16'h1F6, 0, 0);
        step("R6", 1, 1, 16'h176, 0, 8'hEF);
        step("R6", 1, 1, 16'h176, 0, 8'h10);
        step("R6", 1, 1, 16'h1F5, 0, 8'h00);
        step("R6", 1, 1, 16'h3F6, 0, 8'h00);
        step("R6", 1, 1, 16'h1F6, 0, 8'h00);
        // R2 disabled decoding
        step("R2", 0, 0, 0, 0, 0);
        want_io = 0;
        step("R2", 1, 1, 16'h176, 0, 8'h00);
        step("R2", 1, 0, 16'h0000, 0, 0);
        want_io = 1;
        step("R2", 1, 0, 16'h1F0, 0, 0);
        // R7, R8, R11 absent drives (masters fitted only)
        want_pres = 4'b0101;
        step("R7", 1, 1, 16'h1F6, 0, 8'h10);
        step("R7", 1, 0, 16'h1F0, 0, 0);
        step("R7", 1, 0, 16'h3F4, 0, 0);
        step("R8", 1, 0, 16'h1F0, 1, 0);
        step("R8", 1, 1, 16'h3F5, 2, 32'h1);
        step("R11", 1, 0, 16'hC002, 0, 0);
        step("R11", 1, 1, 16'hC00A, 0, 8'h3);
        step("R7", 1, 0, 16'h171, 0, 0);
        step("R6", 1, 1, 16'h1F6, 0, 8'h00);
        step("R7", 1, 0, 16'h1F1, 1, 0);
        // R3 priority with overlapping windows
        want_pres = 4'hF;
        step("R3", 0, 0, 0, 0, 0);
        want_base[2] = 16'h1F0; want_base[1] = 16'h1F0; want_base[3] = 16'h1F0;
        want_base[4] = 16'h3F4;
        step("R3", 1, 0, 16'h1F2, 0, 0);
        step("R3", 1, 0, 16'h1F1, 0, 0);
        step("R3", 1, 0, 16'h1F6, 0, 0);
        step("R3", 1, 0, 16'h3F5, 0, 0);
        step("R3", 1, 0, 16'h3FC, 0, 0);
        // mixed random traffic against the model
        want_base = '{16'h1F0, 16'h3F4, 16'h170, 16'h374, 16'hC000};
        for (int i = 0; i < 400; i++) begin
            int w = $urandom_range(0, 4);
            int a = want_base[w] + $urandom_range(0, want_size[w] + 1);
            if ($urandom_range(0, 9) == 0) a = $urandom_range(0, 16'hFFFF);
            if ($urandom_range(0, 3) == 0) a = want_base[w] + 6;
            want_io = ($urandom_range(0, 7) != 0);
            want_pres = 4'($urandom_range(0, 15));
            step("R10", $urandom_range(0, 4) != 0, 1'($urandom_range(0, 1)), a,
                 $urandom_range(0, 2), int'($urandom));
        end
        step("R10", 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule